// File: doc/BRIEF.md
# External Bus Wait-State Stretch Controller

This block lengthens external bus accesses by a configurable number of wait states. A small configuration register holds two independent stretch counts. Each chip-select line has a two-bit source selector that picks one of four behaviours for accesses to its range: the line is switched off, it uses the first stretch count, it uses the second stretch count, or it waits on an active-low external wait input.

The surrounding bus logic raises `acc_req` for one cycle with a one-hot `acc_cs_idx`. The controller then drives the matching active-low chip select for the whole access and pulses `acc_done` in the final cycle. The source selection, the stretch value and the operating mode are captured when the request is accepted. Programmed or wait-driven stretching applies only while `exp_mode` reports an expanded operating mode. In any other mode every access finishes in its base cycle.

Top module: `xbus_stretch_ctrl`

## Requirements
- R1: After reset `cfg_rdata` reads 0x77: the second stretch count (bits 6..4) and the first stretch count (bits 2..0) are both 7, and bits 7 and 3 read 0.
- R2: A write through `cfg_wr_en`/`cfg_wdata` is accepted in any cycle, including during an access. From the next cycle `cfg_rdata` shows the written value with bits 7 and 3 forced to 0.
- R3: Selector code 01 (bits 2i+1..2i of `cs_src_sel` for line i) in expanded mode gives an access lasting 1 + n cycles, where n is the first stretch count.
- R4: Selector code 10 in expanded mode gives an access lasting 1 + n cycles, where n is the second stretch count.
- R5: A stretch count of 0 gives a single-cycle access, with `acc_done` high in the base cycle.
- R6: Selector code 00 never drives that line's `cs_n` low, and the access still completes in its base cycle.
- R7: Selector code 11 in expanded mode stretches every access by at least 2 cycles (3 cycles in all), even when `wait_n` is already high.
- R8: With code 11, the access ends in the first cycle after the 2-cycle minimum whose `wait_n` value, sampled at that cycle's starting rising edge, is 1 (released).
- R9: With `exp_mode` = 0 at acceptance, every access ends in its base cycle whatever the selector. The chip select is still driven unless the code is 00.
- R10: The selector, the stretch value and the mode are captured at acceptance. A register write in the accept cycle or during the access affects only later accesses.
- R11: During an access exactly the addressed line's `cs_n` is low in every cycle. `acc_done` is a one-cycle pulse in the last cycle, and all `cs_n` are high in the idle cycle that follows.
- R12: `acc_req` raised while an access is in progress is ignored: the running access keeps its line and length, and no new access starts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_mode | input | 1 | 1 when the chip is in an expanded operating mode |
| cfg_wr_en | input | 1 | Write strobe for the stretch register |
| cfg_wdata | input | 8 | Write data for the stretch register |
| cfg_rdata | output | 8 | Current stretch register contents |
| cs_src_sel | input | 2*NUM_CS | Per-line source selector, 2 bits per line |
| acc_req | input | 1 | Access request, accepted when idle |
| acc_cs_idx | input | NUM_CS | One-hot line addressed by the request |
| wait_n | input | 1 | Active-low external wait input |
| cs_n | output | NUM_CS | Active-low chip selects |
| acc_done | output | 1 | One-cycle pulse in the last access cycle |

## Verification
The collision of interest is a register write landing in the same cycle as a request acceptance, or in the middle of an access, where capture and update race. The bench provokes this directly, writing in the accept cycle and at a chosen stretch cycle, and also at random points in the random phase. It judges the result by requiring that the running access keeps the length of the old value while the following access uses the new one. A second overlap, the wait release coinciding with the end of the 2-cycle minimum, is driven by releasing `wait_n` at cycle offsets 1 and 2 and checking the exact access length.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
   typedef enum logic [1:0] {
      SRC_OFF  = 2'b00,
      SRC_CNT0 = 2'b01,
      SRC_CNT1 = 2'b10,
      SRC_WAIT = 2'b11
   } xbs_src_e;
endpackage

// File: rtl/xbs_cfg_reg.sv
module xbs_cfg_reg #(
   parameter int CNT_W = 3,
   localparam int REG_W = 2 * (CNT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [CNT_W-1:0] cnt0,
   output logic [CNT_W-1:0] cnt1
);
   localparam logic [CNT_W-1:0] ONES = '1;
   localparam logic [REG_W-1:0] IMPL_MASK = {1'b0, ONES, 1'b0, ONES};

   if (CNT_W < 1) begin : g_bad_w
      $error("xbs_cfg_reg: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt0 <= ONES;
         cnt1 <= ONES;
      end else if (wr_en) begin
         cnt0 <= wdata[CNT_W-1:0];
         cnt1 <= wdata[2*CNT_W:CNT_W+1];
      end
   end

   assign rdata = {1'b0, cnt1, 1'b0, cnt0};

   assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rdata == ($past(wdata) & IMPL_MASK));
endmodule

// File: rtl/xbs_src_mux.sv
module xbs_src_mux
   import xbs_pkg::*;
#(
   parameter int NUM_CS = 4
) (
   input  logic [NUM_CS-1:0]   cs_idx,
   input  logic [2*NUM_CS-1:0] sel_all,
   output xbs_src_e            src
);
   if (NUM_CS < 1) begin : g_bad_n
      $error("xbs_src_mux: NUM_CS must be at least 1");
   end

   logic [1:0] masked [NUM_CS];
   logic [1:0] acc    [NUM_CS+1];

   assign acc[0] = 2'b00;
   for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      assign masked[i] = sel_all[2*i+1:2*i] & {2{cs_idx[i]}};
      assign acc[i+1]  = acc[i] | masked[i];
   end

   assign src = xbs_src_e'(acc[NUM_CS]);
endmodule

// File: rtl/xbs_timer.sv
module xbs_timer
   import xbs_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int CNT_W    = 3,
   parameter int MIN_WAIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [NUM_CS-1:0] cs_idx,
   input  xbs_src_e          src,
   input  logic [CNT_W-1:0]  cnt0,
   input  logic [CNT_W-1:0]  cnt1,
   input  logic              exp_mode,
   input  logic              wait_n,
   output logic [NUM_CS-1:0] cs_n,
   output logic              done
);
   localparam int MW_W = $clog2(MIN_WAIT + 1);
   localparam int CW   = (CNT_W > MW_W) ? CNT_W : MW_W;

   if (MIN_WAIT < 1) begin : g_bad_min
      $error("xbs_timer: MIN_WAIT must be at least 1");
   end

   logic              act;
   logic [CW-1:0]     cnt;
   logic [NUM_CS-1:0] lat_idx;
   logic              lat_wait;
   logic              lat_exp;
   logic              lat_off;
   logic              wait_q;
   logic [CW-1:0]     load_val;
   logic              use_wait;
   logic              accept;

   assign use_wait = exp_mode && (src == SRC_WAIT);
   assign accept   = req && !act;

   always_comb begin
      load_val = '0;
      if (exp_mode) begin
         unique case (src)
            SRC_CNT0: load_val = CW'(cnt0);
            SRC_CNT1: load_val = CW'(cnt1);
            SRC_WAIT: load_val = CW'(MIN_WAIT);
            default:  load_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= 1'b1;
      else        wait_q <= wait_n;
   end

   assign done = act && (cnt == '0) && (!lat_wait || wait_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act      <= 1'b0;
         cnt      <= '0;
         lat_idx  <= '0;
         lat_wait <= 1'b0;
         lat_exp  <= 1'b0;
         lat_off  <= 1'b0;
      end else if (accept) begin
         act      <= 1'b1;
         cnt      <= load_val;
         lat_idx  <= (src == SRC_OFF) ? '0 : cs_idx;
         lat_wait <= use_wait;
         lat_exp  <= exp_mode;
         lat_off  <= (src == SRC_OFF);
      end else if (act) begin
         if (done)           act <= 1'b0;
         else if (cnt != '0) cnt <= cnt - 1'b1;
      end
   end

   assign cs_n = ~(lat_idx & {NUM_CS{act}});

   assert_cs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_hold_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !done) |=> (act && $stable(cs_n)));
   assert_wait_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lat_wait) |-> ($past(act) && $past(act, 2)));
   assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !lat_exp) |-> !$past(act));
   assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && lat_off) |-> (&cs_n && done));
endmodule

// File: rtl/xbus_stretch_ctrl.sv
module xbus_stretch_ctrl
   import xbs_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int CNT_W    = 3,
   parameter int MIN_WAIT = 2,
   localparam int REG_W   = 2 * (CNT_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                exp_mode,
   input  logic                cfg_wr_en,
   input  logic [REG_W-1:0]    cfg_wdata,
   output logic [REG_W-1:0]    cfg_rdata,
   input  logic [2*NUM_CS-1:0] cs_src_sel,
   input  logic                acc_req,
   input  logic [NUM_CS-1:0]   acc_cs_idx,
   input  logic                wait_n,
   output logic [NUM_CS-1:0]   cs_n,
   output logic                acc_done
);
   logic [CNT_W-1:0] cnt0;
   logic [CNT_W-1:0] cnt1;
   xbs_src_e         src;

   xbs_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr_en),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cnt0  (cnt0),
      .cnt1  (cnt1)
   );

   xbs_src_mux #(.NUM_CS(NUM_CS)) u_mux (
      .cs_idx  (acc_cs_idx),
      .sel_all (cs_src_sel),
      .src     (src)
   );

   xbs_timer #(
      .NUM_CS   (NUM_CS),
      .CNT_W    (CNT_W),
      .MIN_WAIT (MIN_WAIT)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (acc_req),
      .cs_idx   (acc_cs_idx),
      .src      (src),
      .cnt0     (cnt0),
      .cnt1     (cnt1),
      .exp_mode (exp_mode),
      .wait_n   (wait_n),
      .cs_n     (cs_n),
      .done     (acc_done)
   );

   assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |-> ($countones(acc_cs_idx) == 1));
endmodule

// File: tb/sim_xbus_stretch_ctrl.sv
module sim_xbus_stretch_ctrl;
   localparam int CLK_P  = 10;
   localparam int NCS    = 4;
   localparam int WD_MAX = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         exp_mode = 1'b1;
   logic         cfg_wr_en = 1'b0;
   logic [7:0]   cfg_wdata = '0;
   logic [7:0]   cfg_rdata;
   logic [2*NCS-1:0] cs_src_sel = '0;
   logic         acc_req = 1'b0;
   logic [NCS-1:0] acc_cs_idx = 4'b0001;
   logic         wait_n = 1'b1;
   logic [NCS-1:0] cs_n;
   logic         acc_done;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [7:0] shadow = 8'h77;

   always #(CLK_P/2) clk = ~clk;

   xbus_stretch_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .exp_mode(exp_mode),
      .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cs_src_sel(cs_src_sel), .acc_req(acc_req), .acc_cs_idx(acc_cs_idx),
      .wait_n(wait_n), .cs_n(cs_n), .acc_done(acc_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_MAX) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_MAX);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic ok, input int act_v, input int exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
      end
   endtask

   function automatic int exp_len(input logic [1:0] src, input logic [7:0] r,
                                  input logic md, input int j);
      if (!md || src == 2'b00) return 1;
      if (src == 2'b01) return 1 + int'(r[2:0]);
      if (src == 2'b10) return 1 + int'(r[6:4]);
      if (j < 0) return 3;
      return (j + 2 > 3) ? j + 2 : 3;
   endfunction

   function automatic logic [NCS-1:0] exp_cs(input logic [1:0] src, input int cs);
      if (src == 2'b00) return '1;
      return ~(NCS'(1) << cs);
   endfunction

   task automatic wr_reg(input logic [7:0] v);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      shadow = v & 8'h77;
      chk("R2 readback", cfg_rdata == (v & 8'h77), cfg_rdata, v & 8'h77);
   endtask

   // j: wait release cycle (-1 = released all along); wk: write cycle (-2 none, -1 accept cycle)
   // rk: extra request cycle (-1 none)
   task automatic run_acc(input string tag, input int cs, input int j, input int wk,
                          input logic [7:0] wv, input int rk);
      logic [1:0] src;
      int el, len, csbad;
      logic wrote;
      logic [NCS-1:0] ecs;
      src = cs_src_sel[2*cs +: 2];
      el  = exp_len(src, shadow, exp_mode, j);
      ecs = exp_cs(src, cs);
      len = 0; csbad = 0; wrote = 1'b0;
      @(negedge clk);
      acc_cs_idx = NCS'(1) << cs;
      acc_req = 1'b1;
      wait_n = (j < 0);
      if (wk == -1) begin cfg_wr_en = 1'b1; cfg_wdata = wv; wrote = 1'b1; end
      @(negedge clk);
      acc_req = 1'b0;
      cfg_wr_en = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (cs_n !== ecs) csbad++;
         if (acc_done) begin len = i + 1; break; end
         cfg_wr_en = 1'b0;
         acc_req = 1'b0;
         if (i == j) wait_n = 1'b1;
         if (i == wk) begin cfg_wr_en = 1'b1; cfg_wdata = wv; wrote = 1'b1; end
         if (i == rk) begin acc_req = 1'b1; acc_cs_idx = NCS'(1) << ((cs + 1) % NCS); end
         @(negedge clk);
      end
      acc_req = 1'b0;
      cfg_wr_en = 1'b0;
      wait_n = 1'b1;
      if (wrote) shadow = wv & 8'h77;
      chk({tag, " length"}, len == el, len, el);
      chk({tag, " R11 chip select during access"}, csbad == 0, csbad, 0);
      @(negedge clk);
      chk({tag, " R11 idle after done"}, (cs_n == '1) && !acc_done, {cs_n, acc_done}, 5'b11110);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 reset value", cfg_rdata == 8'h77, cfg_rdata, 8'h77);
      chk("R11 reset outputs", (cs_n == '1) && !acc_done, {cs_n, acc_done}, 5'b11110);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: default first count 7
      cs_src_sel = 8'b01_01_01_01;
      run_acc("R3 default cnt0", 2, -1, -2, 8'h00, -1);
      // R4: second count
      cs_src_sel = 8'b10_10_10_10;
      run_acc("R4 default cnt1", 0, -1, -2, 8'h00, -1);
      // R2 register writes
      wr_reg(8'hFF);
      wr_reg(8'h8B);
      wr_reg(8'h35);
      run_acc("R4 cnt1=3", 3, -1, -2, 8'h00, -1);
      cs_src_sel = 8'b01_01_01_01;
      run_acc("R3 cnt0=5", 1, -1, -2, 8'h00, -1);
      wr_reg(8'h30);
      run_acc("R5 zero stretch", 1, -1, -2, 8'h00, -1);
      // R6 disabled line
      cs_src_sel = 8'b01_00_01_01;
      run_acc("R6 disabled", 2, -1, -2, 8'h00, -1);
      // R7 / R8 wait input
      cs_src_sel = 8'b11_11_11_11;
      run_acc("R7 wait released", 0, -1, -2, 8'h00, -1);
      run_acc("R7 wait release at 1", 1, 1, -2, 8'h00, -1);
      run_acc("R8 wait release at 2", 2, 2, -2, 8'h00, -1);
      run_acc("R8 wait release at 6", 3, 6, -2, 8'h00, -1);
      // R9 non-expanded mode
      exp_mode = 1'b0;
      run_acc("R9 wait src", 0, 5, -2, 8'h00, -1);
      cs_src_sel = 8'b10_01_10_01;
      wr_reg(8'h66);
      run_acc("R9 cnt0 src", 0, -1, -2, 8'h00, -1);
      run_acc("R9 cnt1 src", 1, -1, -2, 8'h00, -1);
      exp_mode = 1'b1;
      // R10 write during and at acceptance
      run_acc("R10 write mid access", 0, -1, 1, 8'h02, -1);
      chk("R10 new value visible", cfg_rdata == 8'h02, cfg_rdata, 8'h02);
      run_acc("R10 next access new value", 0, -1, -2, 8'h00, -1);
      run_acc("R10 write in accept cycle", 0, -1, -1, 8'h07, -1);
      run_acc("R10 after accept write", 0, -1, -2, 8'h00, -1);
      // R12 request during access ignored
      run_acc("R12 extra request", 0, -1, 0, 8'h07, 2);
      run_acc("R12 extra request at start", 2, -1, -2, 8'h00, 0);

      // random phase
      for (int n = 0; n < 300; n++) begin
         int cs, j, wk, rk;
         logic [7:0] wv;
         cs_src_sel = 8'($urandom);
         exp_mode = ($urandom % 5) != 0;
         cs = int'($urandom % NCS);
         j  = int'($urandom % 8) - 1;
         wk = (($urandom % 3) == 0) ? int'($urandom % 4) - 1 : -2;
         rk = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
         wv = 8'($urandom);
         run_acc("R3 R4 R7 R8 R9 R10 random", cs, j, wk, wv, rk);
         if (($urandom % 6) == 0) wr_reg(8'($urandom));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule